// File: doc/BRIEF.md
# Filter Output Multiplier Selector

This block turns the normalized output of a digital compensator into the two numbers that a PWM generator uses: a duty count and a period count. The compensator output is an unsigned fraction. The block multiplies it by an operand that is picked at run time. For the duty result, the operand can be the switching period, one of three programmable gain constants, or the upper bits of another filter's output, which serves as feed-forward. For the period result, the operand is either the switching period or the selected gain constant.

Scaling by a gain constant instead of the switching period changes the loop gain, or caps the maximum duty, without moving any pole or zero of the compensator. A constant of half the period caps the duty near 50 % and needs no output clamp. The results are registered. They load only when a new filter sample is flagged as valid.

Top module: `filt_out_scaler`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `duty_out` and `period_out` are 0 after that edge.
- R2: Both outputs load on the rising edge where `sample_vld` is high. They are visible one clock after the strobe. When `sample_vld` is low, the outputs hold their values regardless of any other input.
- R3: Each result equals (filt_out × operand) >> 16, truncated to 14 bits, where `filt_out` is an unsigned 16-bit fraction (0xFFFF just under 1.0).
- R4: `duty_sel` = 0 selects `pwm_period` as the duty operand.
- R5: `duty_sel` = 1 selects gain constant k as the duty operand, where k = `kc_sel` (0..2) and constant k occupies bits [14k+13:14k] of `kc_vals`.
- R6: `duty_sel` = 2 selects feed-forward as the duty operand. The operand is bits [16s+15:16s+2] of `ff_outs` (the top 14 bits of source s), where s = `ff_sel`.
- R7: `per_sel` = 0 selects `pwm_period` as the period operand. `per_sel` = 1 selects the gain constant picked by `kc_sel`.
- R8: Out-of-range selects use `pwm_period` as the operand: `duty_sel` = 3, `kc_sel` = 3 whenever a gain constant is needed, and `ff_sel` ≥ 3 whenever feed-forward is used.
- R9: With a gain constant of P/2 and a full-scale input of 0xFFFF, the duty result is P/2 − 1, which stays below P/2. With `filt_out` = 0x8000 in period mode and an even P, the duty result is exactly P/2.
- R10: A zero filter output gives zero for both results, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | New filter sample strobe |
| filt_out | input | 16 | Filter output fraction |
| pwm_period | input | 14 | Switching period count |
| kc_vals | input | 42 | Three packed 14-bit gain constants |
| kc_sel | input | 2 | Gain constant index |
| ff_outs | input | 48 | Three packed 16-bit outputs of other filters |
| ff_sel | input | 2 | Feed-forward source index |
| duty_sel | input | 2 | Duty operand: 0 period, 1 constant, 2 feed-forward |
| per_sel | input | 1 | Period operand: 0 period, 1 constant |
| duty_out | output | 14 | Registered duty result |
| period_out | output | 14 | Registered period result |

## Verification
The bench builds the block with its default parameters: 16-bit fraction, 14-bit operands, three gain constants and three feed-forward sources. Because three sources and three constants each leave a 2-bit select with one unused code, index 3 exercises the fallback path for both selects, alongside the unused duty mode 3. Every combination of the four selects is swept at zero, mid-scale and full-scale input. The half-period cases are run with an even period of 2500.

// File: rtl/fom_pkg.sv
// Package fom_pkg
// Shared encodings for the filter output multiplier selector.
// Assumes the duty mode select is 2 bits wide; code 3 is reserved.
package fom_pkg;

    typedef enum logic [1:0] {
        DM_PERIOD = 2'd0,
        DM_KCONST = 2'd1,
        DM_FFWD   = 2'd2,
        DM_RSVD   = 2'd3
    } duty_mode_e;

    typedef enum logic {
        PM_PERIOD = 1'b0,
        PM_KCONST = 1'b1
    } per_mode_e;

endpackage

// File: rtl/fom_const_pick.sv
// Module fom_const_pick
// Picks one of NUM_KC packed gain constants by index.
// Assumes an index of NUM_KC or above is invalid. For an invalid index, the
// fallback operand (the switching period) is passed through instead.
module fom_const_pick #(
    parameter int NUM_KC = 3,
    parameter int MULT_W = 14,
    localparam int SEL_W = (NUM_KC > 1) ? $clog2(NUM_KC + 1) : 1
) (
    input  logic [NUM_KC*MULT_W-1:0] consts,
    input  logic [SEL_W-1:0]         sel,
    input  logic [MULT_W-1:0]        fallback,
    output logic [MULT_W-1:0]        picked
);

    // Index lookup with fallback for out-of-range selects
    always_comb begin
        picked = fallback;
        for (int k = 0; k < NUM_KC; k++) begin
            if (int'(sel) == k) begin
                picked = consts[k*MULT_W +: MULT_W];
            end
        end
    end

endmodule

// File: rtl/fom_ffwd_pick.sv
// Module fom_ffwd_pick
// Selects one of NUM_SRC other-filter outputs and keeps its top MULT_W bits
// as a feed-forward operand.
// Assumes FRAC_W >= MULT_W. An out-of-range index yields the fallback operand.
module fom_ffwd_pick #(
    parameter int NUM_SRC = 3,
    parameter int FRAC_W  = 16,
    parameter int MULT_W  = 14,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC + 1) : 1,
    localparam int DROP   = FRAC_W - MULT_W
) (
    input  logic [NUM_SRC*FRAC_W-1:0] srcs,
    input  logic [SEL_W-1:0]          sel,
    input  logic [MULT_W-1:0]         fallback,
    output logic [MULT_W-1:0]         picked
);

    logic [MULT_W-1:0] tops [NUM_SRC];

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_top
            // Upper bits of each source output
            assign tops[g] = srcs[g*FRAC_W + DROP +: MULT_W];
        end
    endgenerate

    // Source lookup with fallback for out-of-range selects
    always_comb begin
        picked = fallback;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int'(sel) == s) begin
                picked = tops[s];
            end
        end
    end

endmodule

// File: rtl/fom_frac_scale.sv
// Module fom_frac_scale
// Multiplies an unsigned FRAC_W-bit fraction by an unsigned MULT_W-bit operand
// and drops the FRAC_W fraction bits. The result is always below the operand
// (or zero), so it fits in MULT_W bits with no saturation.
module fom_frac_scale #(
    parameter int FRAC_W = 16,
    parameter int MULT_W = 14,
    localparam int PROD_W = FRAC_W + MULT_W
) (
    input  logic [FRAC_W-1:0] frac,
    input  logic [MULT_W-1:0] mult,
    output logic [MULT_W-1:0] scaled
);

    logic [PROD_W-1:0] prod;

    // Full-width product, then truncation of the fractional part
    always_comb begin
        prod   = PROD_W'(frac) * PROD_W'(mult);
        scaled = prod[PROD_W-1:FRAC_W];
    end

endmodule

// File: rtl/filt_out_scaler.sv
// Module filt_out_scaler
// Scales a compensator output fraction into a duty count and a period count.
// The duty operand is the period, a gain constant or a feed-forward value.
// The period operand is the period or a gain constant. Both results register
// on a valid strobe.
// Assumes all operand registers are stable when sample_vld is high.
// Synchronous active-low reset.
module filt_out_scaler
    import fom_pkg::*;
#(
    parameter int FRAC_W  = 16,
    parameter int MULT_W  = 14,
    parameter int NUM_KC  = 3,
    parameter int NUM_FF  = 3,
    localparam int KSEL_W = (NUM_KC > 1) ? $clog2(NUM_KC + 1) : 1,
    localparam int FSEL_W = (NUM_FF > 1) ? $clog2(NUM_FF + 1) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_vld,
    input  logic [FRAC_W-1:0]        filt_out,
    input  logic [MULT_W-1:0]        pwm_period,
    input  logic [NUM_KC*MULT_W-1:0] kc_vals,
    input  logic [KSEL_W-1:0]        kc_sel,
    input  logic [NUM_FF*FRAC_W-1:0] ff_outs,
    input  logic [FSEL_W-1:0]        ff_sel,
    input  logic [1:0]               duty_sel,
    input  logic                     per_sel,
    output logic [MULT_W-1:0]        duty_out,
    output logic [MULT_W-1:0]        period_out
);

    logic [MULT_W-1:0] kc_op;
    logic [MULT_W-1:0] ff_op;
    logic [MULT_W-1:0] duty_op;
    logic [MULT_W-1:0] per_op;
    logic [MULT_W-1:0] duty_nx;
    logic [MULT_W-1:0] per_nx;

    fom_const_pick #(.NUM_KC(NUM_KC), .MULT_W(MULT_W)) u_kc (
        .consts  (kc_vals),
        .sel     (kc_sel),
        .fallback(pwm_period),
        .picked  (kc_op)
    );

    fom_ffwd_pick #(.NUM_SRC(NUM_FF), .FRAC_W(FRAC_W), .MULT_W(MULT_W)) u_ff (
        .srcs    (ff_outs),
        .sel     (ff_sel),
        .fallback(pwm_period),
        .picked  (ff_op)
    );

    // Duty operand mux; reserved mode falls back to the period
    always_comb begin
        unique case (duty_mode_e'(duty_sel))
            DM_KCONST: duty_op = kc_op;
            DM_FFWD:   duty_op = ff_op;
            default:   duty_op = pwm_period;
        endcase
    end

    // Period operand mux: only period or gain constant
    always_comb begin
        per_op = (per_mode_e'(per_sel) == PM_KCONST) ? kc_op : pwm_period;
    end

    fom_frac_scale #(.FRAC_W(FRAC_W), .MULT_W(MULT_W)) u_duty_mul (
        .frac  (filt_out),
        .mult  (duty_op),
        .scaled(duty_nx)
    );

    fom_frac_scale #(.FRAC_W(FRAC_W), .MULT_W(MULT_W)) u_per_mul (
        .frac  (filt_out),
        .mult  (per_op),
        .scaled(per_nx)
    );

    // Output registers, loaded only on a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_out   <= '0;
            period_out <= '0;
        end else if (sample_vld) begin
            duty_out   <= duty_nx;
            period_out <= per_nx;
        end
    end

endmodule

// File: rtl/filt_out_scaler_chk.sv
// Module filt_out_scaler_chk
// Port-level properties for filt_out_scaler, attached by bind below.
module filt_out_scaler_chk #(
    parameter int FRAC_W = 16,
    parameter int MULT_W = 14,
    parameter int KSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_vld,
    input logic [FRAC_W-1:0] filt_out,
    input logic [MULT_W-1:0] pwm_period,
    input logic [MULT_W-1:0] kc_first,
    input logic [KSEL_W-1:0] kc_sel,
    input logic [1:0]        duty_sel,
    input logic              per_sel,
    input logic [MULT_W-1:0] duty_out,
    input logic [MULT_W-1:0] period_out
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (duty_out == '0 && period_out == '0));

    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(duty_out) && $stable(period_out)));

    assert_duty_below_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && duty_sel == 2'd0) |=> (duty_out <= $past(pwm_period)));

    assert_period_below_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !per_sel) |=> (period_out <= $past(pwm_period)));

    assert_period_below_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && per_sel && kc_sel == '0) |=> (period_out <= $past(kc_first)));

    assert_zero_in_zero_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && filt_out == '0) |=> (duty_out == '0 && period_out == '0));

endmodule

bind filt_out_scaler filt_out_scaler_chk #(
    .FRAC_W(FRAC_W), .MULT_W(MULT_W), .KSEL_W(KSEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_vld(sample_vld),
    .filt_out  (filt_out),
    .pwm_period(pwm_period),
    .kc_first  (kc_vals[MULT_W-1:0]),
    .kc_sel    (kc_sel),
    .duty_sel  (duty_sel),
    .per_sel   (per_sel),
    .duty_out  (duty_out),
    .period_out(period_out)
);

// File: tb/filt_out_scaler_test.sv
// Directed bench for filt_out_scaler: one task per scenario.
module filt_out_scaler_test;

    localparam int P = 2500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [15:0] filt_out = '0;
    logic [13:0] pwm_period = 14'(P);
    logic [41:0] kc_vals = '0;
    logic [1:0]  kc_sel = '0;
    logic [47:0] ff_outs = '0;
    logic [1:0]  ff_sel = '0;
    logic [1:0]  duty_sel = '0;
    logic        per_sel = 1'b0;
    logic [13:0] duty_out;
    logic [13:0] period_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int kc_tab [3] = '{1250, 3000, 16383};
    int ff_tab [3] = '{32'hFFFF, 32'h8000, 32'h1234};

    filt_out_scaler uut (.*);

    always #2 clk = ~clk;

    function automatic int scale(int f, int m);
        longint p;
        p = longint'(f) * longint'(m);
        return int'(p >> 16);
    endfunction

    // Operand the requirements give for a duty select combination
    function automatic int duty_operand(int ds, int ks, int fs);
        if (ds == 1) return (ks < 3) ? kc_tab[ks] : P;
        if (ds == 2) return (fs < 3) ? (ff_tab[fs] >> 2) : P;
        return P;
    endfunction

    function automatic int per_operand(int ps, int ks);
        if (ps == 1) return (ks < 3) ? kc_tab[ks] : P;
        return P;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_tables();
        for (int k = 0; k < 3; k++) kc_vals[k*14 +: 14] = 14'(kc_tab[k]);
        for (int s = 0; s < 3; s++) ff_outs[s*16 +: 16] = 16'(ff_tab[s]);
    endtask

    // One valid strobe; returns at the negedge after the loading edge
    task automatic strobe(int f);
        @(negedge clk);
        filt_out   = 16'(f);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 duty", int'(duty_out), 0);
        chk("R1 period", int'(period_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_all_combos();
        int fv [3] = '{32'hFFFF, 0, 32'h8000};
        for (int fi = 0; fi < 3; fi++)
            for (int ds = 0; ds < 4; ds++)
                for (int ks = 0; ks < 4; ks++)
                    for (int fs = 0; fs < 4; fs++)
                        for (int ps = 0; ps < 2; ps++) begin
                            string tag;
                            duty_sel = 2'(ds); kc_sel = 2'(ks);
                            ff_sel = 2'(fs); per_sel = 1'(ps);
                            strobe(fv[fi]);
                            if (fv[fi] == 0) tag = "R10";
                            else if (ds == 3 || (ds == 1 && ks == 3) || (ds == 2 && fs == 3)) tag = "R8";
                            else if (ds == 0) tag = "R4";
                            else if (ds == 1) tag = "R5";
                            else tag = "R6";
                            chk({tag, " R3 duty"}, int'(duty_out),
                                scale(fv[fi], duty_operand(ds, ks, fs)));
                            chk({(fv[fi] == 0) ? "R10" : "R7", " period"}, int'(period_out),
                                scale(fv[fi], per_operand(ps, ks)));
                        end
    endtask

    task automatic t_half_period();
        duty_sel = 2'd1; kc_sel = 2'd0; per_sel = 1'b0;
        strobe(32'hFFFF);
        chk("R9 capped duty", int'(duty_out), P / 2 - 1);
        duty_sel = 2'd0;
        strobe(32'h8000);
        chk("R9 exact half", int'(duty_out), P / 2);
    endtask

    task automatic t_hold();
        int d0, p0;
        duty_sel = 2'd0; per_sel = 1'b0;
        strobe(32'h4000);
        d0 = int'(duty_out); p0 = int'(period_out);
        chk("R2 one-cycle load", d0, P / 4);
        filt_out = 16'hFFFF; duty_sel = 2'd2; per_sel = 1'b1; kc_sel = 2'd2;
        repeat (3) @(negedge clk);
        chk("R2 hold duty", int'(duty_out), d0);
        chk("R2 hold period", int'(period_out), p0);
    endtask

    initial begin
        load_tables();
        t_reset();
        t_all_combos();
        t_half_period();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule